// File: doc/BRIEF.md
# Power-Fail Reset and Write-Protect Sequencer

This block supervises the supply of a battery-backed static memory. Two digitized comparator flags feed it. `vok` says the rail is above the write-protect threshold. `vsw` says the rail is above the level where storage switches between the external rail and the backup cell. A free-running `tick` is the timebase for its delays.

From these inputs the block drives four things:
- a reset request for the processor, modelled as the enable of an open-drain pull-down;
- a write-protect flag that forces the memory's chip-enable, write-enable and output-enable inactive;
- a supply-source select;
- a one-time freshness seal that keeps the backup cell disconnected until the first valid power-up.

A four-state machine sequences recovery. `S_DOWN` holds while the rail is bad. When `vok` is sampled high it moves to `S_WPHOLD`, where write-protect and reset are both active and a tick counter runs. Once `WP_TICKS` ticks have been counted it moves to `S_RSTHOLD`, which releases write-protect while reset stays active. Once `RST_TICKS` ticks have been counted it moves to `S_RUN`, which releases reset. From `S_WPHOLD`, `S_RSTHOLD` and `S_RUN`, a low `vok` sends the machine back to `S_DOWN` on the next edge and clears the counter. The ordinary reset `rst_n` also forces `S_DOWN`. The freshness seal is cleared only by `factory_clr`.

Top module: `pwrfail_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises with `vok` low, `wprot` = 1, `rst_pull` = 1 and `batt_sel` = 0.
- R2: From any state, a clock edge that samples `vok` = 0 makes `wprot` = 1 and `rst_pull` = 1 right after that edge.
- R3: While `wprot` = 1, `ce_n_mem`, `we_n_mem` and `oe_n_mem` are 1 whatever the host drives. While `wprot` = 0, they copy `ce_n_in`, `we_n_in` and `oe_n_in`.
- R4: Let E0 be the edge that first samples `vok` = 1 in `S_DOWN`. A tick is counted at each later edge that samples `tick` = 1. `wprot` stays 1 through the edge that counts the `WP_TICKS`-th tick and is 0 from the following edge on.
- R5: `rst_pull` stays 1 through the edge that counts the `RST_TICKS`-th tick and is 0 from the following edge on. Because `RST_TICKS` > `WP_TICKS`, `wprot` is never 1 while `rst_pull` is 0.
- R6: After each edge, `batt_sel` equals `cell_on` AND NOT `vsw`, both as sampled at that edge (1 = backup cell feeds the storage).
- R7: `factory_clr` = 1 sets `cell_on` to 0. After that, `cell_on` becomes 1 on the first edge that samples `vok` = 1 and stays 1 through supply loss and `rst_n` pulses until `factory_clr` is raised again.
- R8: A supply failure during the countdown aborts it. The next recovery counts `WP_TICKS` and `RST_TICKS` again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary asynchronous reset, active low; does not touch the seal |
| factory_clr | input | 1 | Asynchronous seal clear, active high |
| vok | input | 1 | Rail above write-protect threshold |
| vsw | input | 1 | Rail above backup switchover level |
| tick | input | 1 | Timebase pulse, one clock wide |
| ce_n_in | input | 1 | Host chip-enable, active low |
| we_n_in | input | 1 | Host write-enable, active low |
| oe_n_in | input | 1 | Host output-enable, active low |
| ce_n_mem | output | 1 | Gated chip-enable to memory |
| we_n_mem | output | 1 | Gated write-enable to memory |
| oe_n_mem | output | 1 | Gated output-enable to memory |
| wprot | output | 1 | Write protection active |
| rst_pull | output | 1 | 1 = pull the processor reset line low |
| batt_sel | output | 1 | 1 = storage fed from the backup cell |
| cell_on | output | 1 | Backup cell connected (seal broken) |

## Verification
Recovery is tried with tick periods of one to four clocks. These patterns separate counting ticks from counting clocks, and they expose an off-by-one edge at each of the two release points. A failure injected after write-protect has lifted, with reset still held, must bring both flags back at once. The recovery that follows must take the full count again, which separates a restarted counter from a merely paused one. The seal is exercised before the first valid supply, across an ordinary reset and across a factory clear, and the source select is toggled with the cell both sealed and enabled.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
    typedef enum logic [1:0] {
        S_DOWN    = 2'd0,
        S_WPHOLD  = 2'd1,
        S_RSTHOLD = 2'd2,
        S_RUN     = 2'd3
    } pf_state_e;
endpackage

// File: rtl/pwrfail_delay.sv
module pwrfail_delay #(
    parameter int WP_TICKS  = 125,
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic wp_done,
    output logic rst_done
);
    localparam int CW = $clog2(RST_TICKS + 1);
    localparam logic [CW-1:0] WP_LIM  = CW'(WP_TICKS);
    localparam logic [CW-1:0] RST_LIM = CW'(RST_TICKS);

    logic [CW-1:0] cnt;

    // Counter restarts whenever the recovery window is left.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (tick && cnt != RST_LIM)
            cnt <= cnt + 1'b1;
    end

    assign wp_done  = (cnt >= WP_LIM);
    assign rst_done = (cnt == RST_LIM);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RST_LIM);

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> ($stable(cnt) || cnt == '0));
endmodule

// File: rtl/pwrfail_seal.sv
module pwrfail_seal (
    input  logic clk,
    input  logic factory_clr,
    input  logic vok,
    output logic cell_on
);
    // Only the factory clear can restore the seal.
    always_ff @(posedge clk or posedge factory_clr) begin
        if (factory_clr)
            cell_on <= 1'b0;
        else if (vok)
            cell_on <= 1'b1;
    end

    p_seal_sticky_r7: assert property (@(posedge clk) disable iff (factory_clr)
        cell_on |=> cell_on);

    p_seal_break_r7: assert property (@(posedge clk) disable iff (factory_clr)
        vok |=> cell_on);
endmodule

// File: rtl/pwrfail_srcsel.sv
module pwrfail_srcsel (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_on,
    input  logic vsw,
    output logic batt_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            batt_sel <= 1'b0;
        else
            batt_sel <= cell_on & ~vsw;
    end

    p_batt_needs_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> $past(cell_on));
endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
    import pwrfail_pkg::*;
#(
    parameter int WP_TICKS  = 125,
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic factory_clr,
    input  logic vok,
    input  logic vsw,
    input  logic tick,
    input  logic ce_n_in,
    input  logic we_n_in,
    input  logic oe_n_in,
    output logic ce_n_mem,
    output logic we_n_mem,
    output logic oe_n_mem,
    output logic wprot,
    output logic rst_pull,
    output logic batt_sel,
    output logic cell_on
);
    pf_state_e state, state_nx;
    logic      cnt_en, wp_done, rst_done;

    pwrfail_delay #(.WP_TICKS(WP_TICKS), .RST_TICKS(RST_TICKS)) u_delay (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .tick(tick),
        .wp_done(wp_done), .rst_done(rst_done)
    );

    pwrfail_seal u_seal (
        .clk(clk), .factory_clr(factory_clr), .vok(vok), .cell_on(cell_on)
    );

    pwrfail_srcsel u_src (
        .clk(clk), .rst_n(rst_n), .cell_on(cell_on), .vsw(vsw),
        .batt_sel(batt_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_DOWN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_DOWN:    if (vok) state_nx = S_WPHOLD;
            S_WPHOLD:  if (!vok) state_nx = S_DOWN;
                       else if (wp_done) state_nx = S_RSTHOLD;
            S_RSTHOLD: if (!vok) state_nx = S_DOWN;
                       else if (rst_done) state_nx = S_RUN;
            S_RUN:     if (!vok) state_nx = S_DOWN;
        endcase
    end

    always_comb begin
        unique case (state)
            S_DOWN:    begin wprot = 1'b1; rst_pull = 1'b1; cnt_en = 1'b0; end
            S_WPHOLD:  begin wprot = 1'b1; rst_pull = 1'b1; cnt_en = 1'b1; end
            S_RSTHOLD: begin wprot = 1'b0; rst_pull = 1'b1; cnt_en = 1'b1; end
            S_RUN:     begin wprot = 1'b0; rst_pull = 1'b0; cnt_en = 1'b0; end
        endcase
    end

    // Protection forces every memory strobe inactive.
    assign ce_n_mem = ce_n_in | wprot;
    assign we_n_mem = we_n_in | wprot;
    assign oe_n_mem = oe_n_in | wprot;

    p_wp_on_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vok |=> wprot);

    p_rst_on_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vok |=> rst_pull);

    p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pull |-> !wprot);

    p_wp_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wprot) |-> $past(wp_done));

    p_rst_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull) |-> $past(rst_done));
endmodule

// File: tb/test_pwrfail_seq.sv
module test_pwrfail_seq;
    localparam int WP  = 6;
    localparam int RST = 10;
    localparam int NPAT = 4;
    localparam int PERIODS [NPAT] = '{1, 2, 3, 4};

    logic clk = 1'b0;
    logic rst_n, factory_clr, vok, vsw, tick, ce_n_in, we_n_in, oe_n_in;
    logic ce_n_mem, we_n_mem, oe_n_mem, wprot, rst_pull, batt_sel, cell_on;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    pwrfail_seq #(.WP_TICKS(WP), .RST_TICKS(RST)) i_pwrfail_seq (
        .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr), .vok(vok),
        .vsw(vsw), .tick(tick), .ce_n_in(ce_n_in), .we_n_in(we_n_in),
        .oe_n_in(oe_n_in), .ce_n_mem(ce_n_mem), .we_n_mem(we_n_mem),
        .oe_n_mem(oe_n_mem), .wprot(wprot), .rst_pull(rst_pull),
        .batt_sel(batt_sel), .cell_on(cell_on)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise vok with a tick every p clocks and check both release points.
    task automatic recover(input int p);
        @(negedge clk); vok = 1'b1; tick = 1'b0;
        @(posedge clk);
        for (int k = 1; k <= RST * p + 2; k++) begin
            @(negedge clk);
            if (k - 1 == WP * p) begin
                chk("R4 wprot held at last tick", wprot, 1'b1);
                chk("R3 ce gated while protected", ce_n_mem, 1'b1);
                chk("R3 we gated while protected", we_n_mem, 1'b1);
            end
            if (k - 1 == WP * p + 1) begin
                chk("R4 wprot released", wprot, 1'b0);
                chk("R3 we passes after release", we_n_mem, 1'b0);
            end
            if (k - 1 == RST * p) chk("R5 reset held at last tick", rst_pull, 1'b1);
            if (k - 1 == RST * p + 1) chk("R5 reset released", rst_pull, 1'b0);
            tick = (k % p == 0);
        end
        tick = 1'b0;
    endtask

    task automatic fail_supply();
        @(negedge clk); vok = 1'b0;
        @(negedge clk);
        chk("R2 wprot on fail", wprot, 1'b1);
        chk("R2 reset on fail", rst_pull, 1'b1);
        chk("R3 oe gated on fail", oe_n_mem, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; factory_clr = 1'b1; vok = 1'b0; vsw = 1'b0; tick = 1'b0;
        ce_n_in = 1'b0; we_n_in = 1'b0; oe_n_in = 1'b0;
        step(3);
        chk("R1 wprot in reset", wprot, 1'b1);
        chk("R1 reset pull in reset", rst_pull, 1'b1);
        chk("R1 batt_sel in reset", batt_sel, 1'b0);
        chk("R7 sealed after factory clear", cell_on, 1'b0);
        rst_n = 1'b1; factory_clr = 1'b0;
        step(3);
        chk("R1 wprot after reset", wprot, 1'b1);
        chk("R6 sealed cell not selected", batt_sel, 1'b0);
        chk("R7 seal holds without supply", cell_on, 1'b0);
        vsw = 1'b1;

        for (int i = 0; i < NPAT; i++) begin
            recover(PERIODS[i]);
            chk("R7 seal broken by valid supply", cell_on, 1'b1);
            fail_supply();
            chk("R7 cell stays on after fail", cell_on, 1'b1);
        end

        // Source select with the cell enabled.
        @(negedge clk); vsw = 1'b0;
        @(negedge clk);
        chk("R6 backup selected below switchover", batt_sel, 1'b1);
        vsw = 1'b1;
        @(negedge clk);
        chk("R6 rail selected above switchover", batt_sel, 1'b0);

        // Abort during reset hold, then a full recount.
        @(negedge clk); vok = 1'b1; tick = 1'b1;
        step(WP + 4);
        chk("R8 in reset hold before abort wprot", wprot, 1'b0);
        chk("R8 in reset hold before abort reset", rst_pull, 1'b1);
        vok = 1'b0;
        @(negedge clk);
        chk("R8 abort reasserts wprot", wprot, 1'b1);
        chk("R2 abort keeps reset", rst_pull, 1'b1);
        tick = 1'b0;
        step(2);
        recover(1);

        // Ordinary reset must not restore the seal.
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        vok = 1'b0;
        @(negedge clk);
        chk("R7 ordinary reset keeps cell on", cell_on, 1'b1);
        chk("R1 wprot after ordinary reset", wprot, 1'b1);
        factory_clr = 1'b1;
        @(negedge clk);
        factory_clr = 1'b0;
        vsw = 1'b0;
        step(2);
        chk("R7 factory clear reseals", cell_on, 1'b0);
        chk("R6 resealed cell not selected", batt_sel, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule